// File: doc/BRIEF.md
# Synchronous FIFO with Replay and Five-Level Fill Flags

A single-clock first-in first-out buffer for 18-bit words whose depth is a power of two set by a parameter. Words are pushed with an active-low write strobe and popped with an active-low read strobe. A popped word lands in a registered output stage one edge after the request. That register keeps its last value whenever no read is accepted, including reads attempted on an empty buffer. The fill level is reported on five active-low flags: empty, almost-empty, half-full, almost-full and full. The two "almost" thresholds are supplied as inputs by a neighbouring offset register block.

A replay strobe moves the read position back to physical slot zero. Everything written since reset can then be read out again, as long as no more than the depth was written. While the strobe is high the buffer runs a small control state machine with three states. ST_RUN is normal operation. The edge that samples the strobe high moves it to ST_REWIND. ST_REWIND stays put while the strobe is held. The first edge with the strobe low moves it to ST_RECOVER, a one-cycle settling state. ST_RECOVER goes back to ST_RUN, or to ST_REWIND again if the strobe returns. Reads and writes are accepted only in ST_RUN while the strobe is low.

The occupancy counter is one bit wider than the address. All flags are registered from the next-cycle occupancy, so they are exact immediately after the edge that changed the fill level.

Top module: `rtx_fifo`

## Requirements
- R1: At a rising edge with `wr_n` low, `full_n` high, `rt` low and the controller in ST_RUN, `din` is stored. Stored words come out in the order they were written.
- R2: At a rising edge with `rd_n` low, `empty_n` high, `rt` low and the controller in ST_RUN, the oldest word is moved into `dout`, where it is visible right after that edge.
- R3: While `full_n` is low, a write request is discarded. The word never appears at `dout` and the occupancy stays at the depth.
- R4: While `empty_n` is low, a read request is discarded and `dout` keeps the last word read.
- R5: A read and a write accepted at the same edge leave the occupancy, and so every flag, unchanged. At 0 words only the write is taken; at full only the read is taken.
- R6: `empty_n` is low exactly when the buffer holds 0 words. `full_n` is low exactly when it holds DEPTH words.
- R7: `aempty_n` is low exactly when the occupancy is less than or equal to `ae_ofs`.
- R8: `half_n` is low exactly when the occupancy is greater than DEPTH/2.
- R9: `afull_n` is low exactly when the occupancy plus `af_ofs` is at least DEPTH.
- R10: Every edge at which `rt` is high sets the read position to physical slot 0 and sets the occupancy to the number of writes since reset (at most DEPTH). Later reads replay the earlier words in order, and the flags follow the new occupancy.
- R11: Read and write requests are ignored at every edge where `rt` is high, and at the single ST_RECOVER edge after it falls. `dout` and the stored words are not touched by those requests.
- R12: While `rst_n` is low, `empty_n` and `aempty_n` are low, `half_n`, `afull_n` and `full_n` are high, `dout` is zero and the controller is in ST_RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_n | input | 1 | Write request, active low |
| din | input | WIDTH | Word to store |
| rd_n | input | 1 | Read request, active low |
| rt | input | 1 | Replay strobe, active high |
| ae_ofs | input | AW+1 | Almost-empty threshold n |
| af_ofs | input | AW+1 | Almost-full distance m from full |
| dout | output | WIDTH | Registered output word |
| empty_n | output | 1 | Low at 0 words |
| aempty_n | output | 1 | Low at n words or fewer |
| half_n | output | 1 | Low above DEPTH/2 words |
| afull_n | output | 1 | Low at DEPTH−m words or more |
| full_n | output | 1 | Low at DEPTH words |

## Verification
Two kinds of event can fall on the same edge. The first is a read and a write together. The bench issues both requests at once at 0 words, at several middle levels and at full, and expects the occupancy to be unchanged in the middle and exactly one side to be accepted at the two boundaries. The second is a replay strobe together with read and write requests. The bench holds both requests low through the strobe and the settling cycle, then expects `dout` to be unchanged, the flags to follow the occupancy written since reset, and the replayed data to start from the first word ever written.

// File: rtl/rtx_fifo_pkg.sv
`timescale 1ns/1ps
package rtx_fifo_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_REWIND  = 2'd1,
        ST_RECOVER = 2'd2
    } rt_state_e;

    typedef struct packed {
        logic empty_n;
        logic aempty_n;
        logic half_n;
        logic afull_n;
        logic full_n;
    } flag_bus_t;

endpackage

// File: rtl/rtx_fifo_ctrl.sv
`timescale 1ns/1ps
module rtx_fifo_ctrl
    import rtx_fifo_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          rt,
    output logic          wr_en,
    output logic          rd_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   cnt_nxt
);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(1 << AW);

    rt_state_e     state, state_nxt;
    logic [CW-1:0] wr_ptr, rd_ptr, cnt, rd_ptr_nxt;
    logic          open;

    // next-state decode
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:     state_nxt = rt ? ST_REWIND : ST_RUN;
            ST_REWIND:  state_nxt = rt ? ST_REWIND : ST_RECOVER;
            ST_RECOVER: state_nxt = rt ? ST_REWIND : ST_RUN;
            default:    state_nxt = ST_RUN;
        endcase
    end

    // output decode: accepts, next occupancy, next read position
    always_comb begin
        open  = (state == ST_RUN) && !rt;
        wr_en = open && !wr_n && (cnt != FULL_CNT);
        rd_en = open && !rd_n && (cnt != '0);
        if (rt) begin
            cnt_nxt    = wr_ptr;
            rd_ptr_nxt = '0;
        end else begin
            unique case ({wr_en, rd_en})
                2'b10:   cnt_nxt = cnt + CW'(1);
                2'b01:   cnt_nxt = cnt - CW'(1);
                default: cnt_nxt = cnt;
            endcase
            rd_ptr_nxt = rd_ptr + CW'(rd_en);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_RUN;
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            state  <= state_nxt;
            wr_ptr <= wr_ptr + CW'(wr_en);
            rd_ptr <= rd_ptr_nxt;
            cnt    <= cnt_nxt;
        end
    end

    assign wr_addr = wr_ptr[AW-1:0];
    assign rd_addr = rd_ptr[AW-1:0];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT); // R3
    AST_RT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rt |=> $stable(wr_ptr)); // R11
    AST_RECOVER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVER && !rt) |=> ($stable(wr_ptr) && $stable(rd_ptr))); // R11
    AST_RT_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
        rt |=> (rd_ptr == '0)); // R10

endmodule

// File: rtl/rtx_fifo_mem.sv
`timescale 1ns/1ps
module rtx_fifo_mem #(
    parameter int AW    = 9,
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] din,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] dout
);
    localparam int DEPTH = 1 << AW;

    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     dout <= '0;
        else if (rd_en) dout <= store[rd_addr];
    end

    AST_PORTS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en) |-> (wr_addr != rd_addr)); // R5

endmodule

// File: rtl/rtx_fifo_flags.sv
`timescale 1ns/1ps
module rtx_fifo_flags
    import rtx_fifo_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [AW:0] cnt_nxt,
    input  logic [AW:0] ae_ofs,
    input  logic [AW:0] af_ofs,
    output flag_bus_t   flags
);
    localparam int CW = AW + 1;
    localparam logic [CW:0] FULL_X = (CW+1)'(1 << AW);
    localparam logic [CW:0] HALF_X = (CW+1)'(1 << (AW - 1));

    logic [CW:0] cnt_x, sum_x;

    assign cnt_x = {1'b0, cnt_nxt};
    assign sum_x = cnt_x + {1'b0, af_ofs};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '{empty_n: 1'b0, aempty_n: 1'b0, half_n: 1'b1,
                       afull_n: 1'b1, full_n: 1'b1};
        end else begin
            flags.empty_n  <= (cnt_x != '0);
            flags.aempty_n <= (cnt_nxt > ae_ofs);
            flags.half_n   <= (cnt_x <= HALF_X);
            flags.afull_n  <= (sum_x < FULL_X);
            flags.full_n   <= (cnt_x != FULL_X);
        end
    end

    AST_EMPTY_NESTS: assert property (@(posedge clk) disable iff (!rst_n)
        !flags.empty_n |-> !flags.aempty_n); // R7
    AST_FULL_NESTS: assert property (@(posedge clk) disable iff (!rst_n)
        !flags.full_n |-> (!flags.afull_n && !flags.half_n)); // R9
    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flags.empty_n && !flags.half_n)); // R8

endmodule

// File: rtl/rtx_fifo.sv
`timescale 1ns/1ps
module rtx_fifo
    import rtx_fifo_pkg::*;
#(
    parameter int AW    = 9,
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic [WIDTH-1:0] din,
    input  logic             rd_n,
    input  logic             rt,
    input  logic [AW:0]      ae_ofs,
    input  logic [AW:0]      af_ofs,
    output logic [WIDTH-1:0] dout,
    output logic             empty_n,
    output logic             aempty_n,
    output logic             half_n,
    output logic             afull_n,
    output logic             full_n
);
    logic          wr_en, rd_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [AW:0]   cnt_nxt;
    flag_bus_t     flags;

    rtx_fifo_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt(rt),
        .wr_en(wr_en), .rd_en(rd_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .cnt_nxt(cnt_nxt)
    );

    rtx_fifo_mem #(.AW(AW), .WIDTH(WIDTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .din(din),
        .rd_en(rd_en), .rd_addr(rd_addr), .dout(dout)
    );

    rtx_fifo_flags #(.AW(AW)) u_flags (
        .clk(clk), .rst_n(rst_n), .cnt_nxt(cnt_nxt),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs), .flags(flags)
    );

    assign empty_n  = flags.empty_n;
    assign aempty_n = flags.aempty_n;
    assign half_n   = flags.half_n;
    assign afull_n  = flags.afull_n;
    assign full_n   = flags.full_n;

    AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && rd_n && !rt) |=> !full_n); // R3
    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |=> $stable(dout)); // R4
    AST_RT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rt |=> $stable(dout)); // R11
    AST_BOTH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en) |=> ($stable(empty_n) && $stable(full_n))); // R5

endmodule

// File: tb/rtx_fifo_bench.sv
`timescale 1ns/1ps
module rtx_fifo_bench;
    localparam int AW = 3;
    localparam int DP = 1 << AW;
    localparam int W  = 18;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_n = 1'b1, rd_n = 1'b1, rt = 1'b0;
    logic [W-1:0] din = '0;
    logic [AW:0]  ae_ofs = '0, af_ofs = '0;
    logic [W-1:0] dout;
    logic empty_n, aempty_n, half_n, afull_n, full_n;

    always #2 clk = ~clk;

    rtx_fifo #(.AW(AW), .WIDTH(W)) u_rtx_fifo (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .din(din), .rd_n(rd_n), .rt(rt),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs), .dout(dout), .empty_n(empty_n),
        .aempty_n(aempty_n), .half_n(half_n), .afull_n(afull_n), .full_n(full_n)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model
    int mcnt, mwr, mrd, mode;
    logic [W-1:0] mmem [DP];
    logic [W-1:0] exp_dout;
    int seq = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        int n = int'(ae_ofs);
        int m = int'(af_ofs);
        chk(empty_n  == (mcnt != 0),      "R6", "empty_n",  empty_n,  mcnt != 0);
        chk(full_n   == (mcnt != DP),     "R6", "full_n",   full_n,   mcnt != DP);
        chk(aempty_n == (mcnt > n),       "R7", "aempty_n", aempty_n, mcnt > n);
        chk(half_n   == (mcnt <= DP/2),   "R8", "half_n",   half_n,   mcnt <= DP/2);
        chk(afull_n  == (mcnt + m < DP),  "R9", "afull_n",  afull_n,  mcnt + m < DP);
        chk(dout == exp_dout, req, "dout", int'(dout), int'(exp_dout));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt = 1'b0;
        mcnt = 0; mwr = 0; mrd = 0; mode = 0; exp_dout = '0;
        repeat (2) @(negedge clk);
        chk(empty_n == 1'b0 && aempty_n == 1'b0, "R12", "low flags",
            {empty_n, aempty_n}, 0);
        chk(half_n && afull_n && full_n, "R12", "high flags",
            {half_n, afull_n, full_n}, 7);
        chk(dout == '0, "R12", "dout", int'(dout), 0);
        rst_n = 1'b1;
    endtask

    task automatic step(input bit w, input bit r, input bit t, input string req);
        bit open, wa, ra;
        logic [W-1:0] d;
        seq++;
        d = W'(32'h15A00 ^ (seq * 7));
        @(negedge clk);
        wr_n = !w; rd_n = !r; rt = t; din = d;
        @(posedge clk);
        #1;
        open = (mode == 0) && !t;
        wa = open && w && (mcnt < DP);
        ra = open && r && (mcnt > 0);
        if (ra) begin exp_dout = mmem[mrd % DP]; mrd++; end
        if (wa) begin mmem[mwr % DP] = d; mwr++; end
        if (t) begin mrd = 0; mcnt = mwr; end
        else mcnt = mcnt + int'(wa) - int'(ra);
        if (t) mode = 1; else if (mode == 1) mode = 2; else mode = 0;
        check_state(req);
    endtask

    task automatic idle();
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b1; rt = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        ae_ofs = 4'd2; af_ofs = 4'd2;
        // R1 fill, R3 overflow attempt
        for (int i = 0; i < DP; i++) step(1, 0, 0, "R1");
        step(1, 0, 0, "R3");
        step(1, 0, 0, "R3");
        // R2/R3 drain: blocked words never appear
        for (int i = 0; i < DP; i++) step(0, 1, 0, "R3");
        // R4 empty reads hold last word
        step(0, 1, 0, "R4");
        step(0, 1, 0, "R4");
        // R5 simultaneous access at empty, middle levels, full
        step(1, 1, 0, "R5");
        for (int lvl = 1; lvl < DP; lvl++) begin
            step(1, 1, 0, "R5");
            step(1, 0, 0, "R2");
        end
        step(1, 1, 0, "R5");
        for (int i = 0; i < DP; i++) step(0, 1, 0, "R2");
        // R7/R9 offset sweep over every threshold
        for (int n = 0; n <= DP; n++) begin
            for (int m = 0; m <= DP; m++) begin
                idle();
                ae_ofs = (AW+1)'(n); af_ofs = (AW+1)'(m);
                for (int i = 0; i < DP; i++) step(1, 0, 0, "R7");
                for (int i = 0; i < DP; i++) step(0, 1, 0, "R9");
            end
        end
        // R10/R11 replay with requests held during strobe and settling
        do_reset();
        ae_ofs = 4'd1; af_ofs = 4'd1;
        for (int i = 0; i < 5; i++) step(1, 0, 0, "R1");
        for (int i = 0; i < 3; i++) step(0, 1, 0, "R2");
        step(1, 1, 1, "R11");
        step(1, 1, 1, "R11");
        step(1, 1, 0, "R11");
        for (int i = 0; i < 5; i++) step(0, 1, 0, "R10");
        step(0, 1, 0, "R4");
        for (int i = 0; i < 3; i++) step(1, 0, 0, "R1");
        step(0, 0, 1, "R10");
        step(0, 0, 0, "R11");
        for (int i = 0; i < DP; i++) step(0, 1, 0, "R10");
        step(0, 1, 0, "R4");
        idle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule